// File: doc/BRIEF.md
# Calendar Time Counter with Alarm

This block keeps wall-clock time and a calendar from a slow enable tick: seconds, minutes, hours, day of week, day of month, month, a two-digit year and a century count. A prescaler divides the tick down to one rollover per second. Each rollover advances the calendar one second, with month lengths and leap years handled. A busy flag warns of the coming rollover a few ticks early. A one-cycle done strobe follows each rollover, and an alarm strobe follows any rollover at which the new time matches the programmed alarm.

Internally every field is held in binary. The outputs, the host loads and the alarm bytes are all read through the format chosen by two control inputs: binary or packed decimal, and 24-hour or 12-hour with a PM flag. When the host flips either bit, the outputs switch to the new format at once. A freeze input stops counting so that the host can load fields. A three-bit divider code can stop the timebase or hold the prescaler in reset. When the prescaler is released from reset, the first rollover comes half a second later.

Top module: `rtcal_top`

## Requirements
- R1: Time advances only when `setFreeze` is 0 and `divSel` is 0, 1 or 2. With codes 3, 4 or 5 the prescaler holds and no events occur. After reset the time is 00:00:00, weekday 1, date 1, month 1, year 0, century 0.
- R2: While `divSel` is 6 or 7 the prescaler is held at zero, and `updBusy`, `updDone` and `alarmHit` all stay low.
- R3: When `divSel` leaves 6 or 7, the first rollover happens TICKS_PER_SEC/2 ticks later.
- R4: `updBusy` is high for the last BUSY_TICKS ticks before each rollover and falls at the clock edge that advances the time. `updDone` pulses for exactly the one cycle after that edge, with the new time already visible.
- R5: With `binMode`=1 each field is output as a plain binary byte. With `binMode`=0 it is output as packed decimal, tens in bits 7:4 and units in bits 3:0.
- R6: With `hour24`=1 hours read 0 to 23. With `hour24`=0 they read 1 to 12, with bit 7 set for PM: hour 0 reads 12 with bit 7 clear, and hour 12 reads 12 with bit 7 set.
- R7: Seconds and minutes wrap at 59 and hours at 23. Weekday runs 1 to 7 and advances with the date. The date wraps after 28, 29, 30 or 31 days according to the month, and February has 29 days when year mod 4 is 0. Month runs 1 to 12. When the year wraps from 99 to 0, the century increments.
- R8: An alarm byte whose bits 7:6 are both 1 matches anything. `alarmHit` pulses together with `updDone` when every other alarm field equals the new time, and stays low otherwise.
- R9: Alarm bytes are decoded in the current format. The alarm hour follows the same 12/24-hour rules as R6.
- R10: A load (`loadEn`=1) writes `loadData`, decoded in the current format, into the field selected by `loadIdx`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century. A load is taken only while `setFreeze`=1 and is ignored otherwise.
- R11: While `setFreeze`=1 the time holds still, and `updBusy`, `updDone` and `alarmHit` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | Timebase enable, one pulse per timebase tick |
| divSel | input | 3 | Divider code: 0-2 run, 3-5 stopped, 6-7 prescaler reset |
| setFreeze | input | 1 | Freeze counting and allow loads |
| binMode | input | 1 | 1 = binary fields, 0 = packed decimal |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag in bit 7 |
| loadEn | input | 1 | Field load strobe |
| loadIdx | input | 3 | Field selected for load |
| loadData | input | 8 | Load byte in the current format |
| alarmSec | input | 8 | Alarm seconds (bits 7:6 = 11 means any) |
| alarmMin | input | 8 | Alarm minutes (bits 7:6 = 11 means any) |
| alarmHour | input | 8 | Alarm hours (bits 7:6 = 11 means any) |
| timeSec | output | 8 | Seconds |
| timeMin | output | 8 | Minutes |
| timeHour | output | 8 | Hours |
| timeWeekday | output | 8 | Day of week |
| timeDate | output | 8 | Day of month |
| timeMonth | output | 8 | Month |
| timeYear | output | 8 | Year within century |
| timeCentury | output | 8 | Century |
| updBusy | output | 1 | Rollover imminent |
| updDone | output | 1 | One-cycle strobe after a rollover |
| alarmHit | output | 1 | One-cycle strobe on an alarm match |

## Verification
The update-ended strobe and the alarm strobe can fire in the same cycle. The bench makes this happen at a rollover that also carries through every field, from 23:59:59 on 31 December of year 99 to midnight of the next century. It then repeats the case in binary 12-hour format with the alarm hour given as 12 AM. For each expected rollover a scoreboard entry records the full time and whether the alarm strobe should fire. The monitor judges the time and the alarm strobe together at every done pulse. Each release from prescaler reset is also timed, to check the half-second delay and the length of the busy window.

// File: rtl/rtcal_pkg.sv
`timescale 1ns/1ps
package rtcal_pkg;

  typedef struct packed {
    logic advance;   // one-second rollover this edge
    logic load;      // accepted host field load this edge
  } rtcal_strobe_t;

  function automatic logic [7:0] encField(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = v / 7'd10;
    units = v % 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [6:0] decField(input logic [7:0] b, input logic bin);
    logic [6:0] tens;
    tens = {3'b000, b[7:4]};
    return bin ? b[6:0] : (tens * 7'd10 + {3'b000, b[3:0]});
  endfunction

  function automatic logic [7:0] encHour(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] h12;
    logic [7:0] e;
    h12 = (h == 5'd0) ? 5'd12 : ((h > 5'd12) ? h - 5'd12 : h);
    e   = encField({2'b00, h12}, bin);
    return h24 ? encField({2'b00, h}, bin) : {(h >= 5'd12), e[6:0]};
  endfunction

  function automatic logic [4:0] decHour(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] v;
    logic [4:0] base;
    v    = h24 ? decField(b, bin) : decField({1'b0, b[6:0]}, bin);
    base = (v == 7'd12) ? 5'd0 : v[4:0];
    return h24 ? v[4:0] : base + (b[7] ? 5'd12 : 5'd0);
  endfunction

  function automatic logic [4:0] monthDays(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtcal_ctrl.sv
`timescale 1ns/1ps
module rtcal_ctrl
  import rtcal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick32k,
  input  logic [2:0]    divSel,
  input  logic          setFreeze,
  input  logic          loadEn,
  output rtcal_strobe_t strb,
  output logic          updBusy,
  output logic          updDone
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST_V = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_V = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] BUSY_V = CW'(TICKS_PER_SEC - BUSY_TICKS);

  logic [CW-1:0] cnt;
  logic prevReset;
  logic oscOn, divReset, running, releasing;

  assign oscOn     = (divSel <= 3'd2);
  assign divReset  = (divSel[2:1] == 2'b11);
  assign running   = oscOn && !setFreeze;
  assign releasing = prevReset && !divReset;

  assign strb.advance = tick32k && running && !releasing && (cnt == LAST_V);
  assign strb.load    = loadEn && setFreeze;
  assign updBusy      = running && (cnt >= BUSY_V);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      prevReset <= 1'b0;
      updDone   <= 1'b0;
    end else begin
      prevReset <= divReset;
      updDone   <= strb.advance;
      if (divReset)            cnt <= '0;
      else if (releasing)      cnt <= HALF_V;
      else if (tick32k && oscOn) cnt <= (cnt == LAST_V) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtcal_data.sv
`timescale 1ns/1ps
module rtcal_data
  import rtcal_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  rtcal_strobe_t strb,
  input  logic          binMode,
  input  logic          hour24,
  input  logic [2:0]    loadIdx,
  input  logic [7:0]    loadData,
  input  logic [7:0]    alarmSec,
  input  logic [7:0]    alarmMin,
  input  logic [7:0]    alarmHour,
  output logic [7:0]    timeSec,
  output logic [7:0]    timeMin,
  output logic [7:0]    timeHour,
  output logic [7:0]    timeWeekday,
  output logic [7:0]    timeDate,
  output logic [7:0]    timeMonth,
  output logic [7:0]    timeYear,
  output logic [7:0]    timeCentury,
  output logic          alarmMatch
);
  logic [5:0] sec, min;
  logic [4:0] hour, date;
  logic [2:0] wday;
  logic [3:0] month;
  logic [6:0] year, cent;

  logic [6:0] ldVal;
  logic [4:0] ldHour;
  logic secEnd, minEnd, hourEnd, dateEnd, monthEnd, yearEnd;

  assign ldVal  = decField(loadData, binMode);
  assign ldHour = decHour(loadData, binMode, hour24);

  assign secEnd   = (sec == 6'd59);
  assign minEnd   = secEnd && (min == 6'd59);
  assign hourEnd  = minEnd && (hour == 5'd23);
  assign dateEnd  = hourEnd && (date == monthDays(month, year));
  assign monthEnd = dateEnd && (month == 4'd12);
  assign yearEnd  = monthEnd && (year == 7'd99);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec <= '0; min <= '0; hour <= '0;
      wday <= 3'd1; date <= 5'd1; month <= 4'd1;
      year <= '0; cent <= '0;
    end else if (strb.advance) begin
      sec <= secEnd ? 6'd0 : sec + 6'd1;
      if (secEnd)  min  <= minEnd ? 6'd0 : min + 6'd1;
      if (minEnd)  hour <= hourEnd ? 5'd0 : hour + 5'd1;
      if (hourEnd) begin
        wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
        date <= dateEnd ? 5'd1 : date + 5'd1;
      end
      if (dateEnd)  month <= monthEnd ? 4'd1 : month + 4'd1;
      if (monthEnd) year  <= yearEnd ? 7'd0 : year + 7'd1;
      if (yearEnd)  cent  <= (cent == 7'd99) ? 7'd0 : cent + 7'd1;
    end else if (strb.load) begin
      case (loadIdx)
        3'd0:    sec   <= ldVal[5:0];
        3'd1:    min   <= ldVal[5:0];
        3'd2:    hour  <= ldHour;
        3'd3:    wday  <= ldVal[2:0];
        3'd4:    date  <= ldVal[4:0];
        3'd5:    month <= ldVal[3:0];
        3'd6:    year  <= ldVal;
        default: cent  <= ldVal;
      endcase
    end
  end

  assign timeSec     = encField({1'b0, sec}, binMode);
  assign timeMin     = encField({1'b0, min}, binMode);
  assign timeHour    = encHour(hour, binMode, hour24);
  assign timeWeekday = encField({4'b0, wday}, binMode);
  assign timeDate    = encField({2'b0, date}, binMode);
  assign timeMonth   = encField({3'b0, month}, binMode);
  assign timeYear    = encField(year, binMode);
  assign timeCentury = encField(cent, binMode);

  logic secOk, minOk, hourOk;
  assign secOk  = (alarmSec[7:6] == 2'b11)  || (decField(alarmSec, binMode) == {1'b0, sec});
  assign minOk  = (alarmMin[7:6] == 2'b11)  || (decField(alarmMin, binMode) == {1'b0, min});
  assign hourOk = (alarmHour[7:6] == 2'b11) || (decHour(alarmHour, binMode, hour24) == hour);
  assign alarmMatch = secOk && minOk && hourOk;
endmodule

// File: rtl/rtcal_top.sv
`timescale 1ns/1ps
module rtcal_top
  import rtcal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic [2:0] divSel,
  input  logic       setFreeze,
  input  logic       binMode,
  input  logic       hour24,
  input  logic       loadEn,
  input  logic [2:0] loadIdx,
  input  logic [7:0] loadData,
  input  logic [7:0] alarmSec,
  input  logic [7:0] alarmMin,
  input  logic [7:0] alarmHour,
  output logic [7:0] timeSec,
  output logic [7:0] timeMin,
  output logic [7:0] timeHour,
  output logic [7:0] timeWeekday,
  output logic [7:0] timeDate,
  output logic [7:0] timeMonth,
  output logic [7:0] timeYear,
  output logic [7:0] timeCentury,
  output logic       updBusy,
  output logic       updDone,
  output logic       alarmHit
);
  rtcal_strobe_t strb;
  logic alarmMatch;

  rtcal_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC), .BUSY_TICKS(BUSY_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .divSel(divSel),
    .setFreeze(setFreeze), .loadEn(loadEn), .strb(strb),
    .updBusy(updBusy), .updDone(updDone)
  );

  rtcal_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .binMode(binMode), .hour24(hour24),
    .loadIdx(loadIdx), .loadData(loadData),
    .alarmSec(alarmSec), .alarmMin(alarmMin), .alarmHour(alarmHour),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour),
    .timeWeekday(timeWeekday), .timeDate(timeDate), .timeMonth(timeMonth),
    .timeYear(timeYear), .timeCentury(timeCentury), .alarmMatch(alarmMatch)
  );

  assign alarmHit = updDone && alarmMatch;
endmodule

// File: rtl/rtcal_checks.sv
`timescale 1ns/1ps
module rtcal_checks (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] divSel,
  input logic       setFreeze,
  input logic       binMode,
  input logic       hour24,
  input logic       loadEn,
  input logic [7:0] timeSec,
  input logic [7:0] timeHour,
  input logic       updBusy,
  input logic       updDone,
  input logic       alarmHit
);
  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (divSel[2:1] == 2'b11) && $past(divSel[2:1] == 2'b11) |-> !updDone && !updBusy);

  assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    updDone |-> !updBusy);

  assert_busy_before_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updDone) |-> $past(updBusy));

  assert_alarm_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |-> updDone);

  assert_frozen_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(setFreeze) && !$past(loadEn) && $stable(binMode) && $stable(hour24)
      |-> $stable(timeSec) && $stable(timeHour));
endmodule

bind rtcal_top rtcal_checks u_checks (
  .clk(clk), .rstN(rstN), .divSel(divSel), .setFreeze(setFreeze),
  .binMode(binMode), .hour24(hour24), .loadEn(loadEn),
  .timeSec(timeSec), .timeHour(timeHour),
  .updBusy(updBusy), .updDone(updDone), .alarmHit(alarmHit)
);

// File: tb/test_rtcal_top.sv
`timescale 1ns/1ps
module test_rtcal_top;
  localparam int TICKS = 64;
  localparam int BUSYT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick32k = 1'b1;
  logic [2:0] divSel = 3'b110;
  logic setFreeze = 1'b1, binMode = 1'b0, hour24 = 1'b1, loadEn = 1'b0;
  logic [2:0] loadIdx = 3'd0;
  logic [7:0] loadData = 8'h00;
  logic [7:0] alarmSec = 8'h60, alarmMin = 8'hC0, alarmHour = 8'hC0;
  logic [7:0] timeSec, timeMin, timeHour, timeWeekday, timeDate, timeMonth, timeYear, timeCentury;
  logic updBusy, updDone, alarmHit;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  typedef struct { logic [63:0] t; logic alm; string tag; } exp_t;
  exp_t q[$];

  rtcal_top #(.TICKS_PER_SEC(TICKS), .BUSY_TICKS(BUSYT)) i_rtcal_top (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .divSel(divSel), .setFreeze(setFreeze),
    .binMode(binMode), .hour24(hour24), .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .alarmSec(alarmSec), .alarmMin(alarmMin), .alarmHour(alarmHour),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour), .timeWeekday(timeWeekday),
    .timeDate(timeDate), .timeMonth(timeMonth), .timeYear(timeYear), .timeCentury(timeCentury),
    .updBusy(updBusy), .updDone(updDone), .alarmHit(alarmHit)
  );

  always #2.5 clk = ~clk;

  function automatic logic [63:0] nowTime();
    return {timeCentury, timeYear, timeMonth, timeDate, timeWeekday, timeHour, timeMin, timeSec};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // monitor: pop one expected rollover per done strobe
  always @(negedge clk) begin
    exp_t e;
    if (rstN && updDone) begin
      if (q.size() == 0) check(1'b0, "R4 unexpected done strobe", 64'(updDone), 64'd0);
      else begin
        e = q.pop_front();
        check(nowTime() == e.t, {e.tag, " time"}, nowTime(), e.t);
        check(alarmHit == e.alm, {e.tag, " alarm"}, 64'(alarmHit), 64'(e.alm));
      end
    end
  end

  task automatic expectRoll(input logic [63:0] t, input logic alm, input string tag);
    exp_t e;
    e.t = t; e.alm = alm; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic loadField(input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk); #1;
    loadEn = 1'b1; loadIdx = idx; loadData = data;
    @(negedge clk); #1;
    loadEn = 1'b0;
  endtask

  task automatic setTime(input int h, input int m, input int s, input int wd, input int d, input int mo, input int y);
    loadField(3'd2, 8'(h)); loadField(3'd1, 8'(m)); loadField(3'd0, 8'(s));
    loadField(3'd3, 8'(wd)); loadField(3'd4, 8'(d)); loadField(3'd5, 8'(mo));
    loadField(3'd6, 8'(y));
  endtask

  // release from prescaler reset, run until every queued rollover is seen
  task automatic runUntilDrained();
    int k, firstDone, busyCnt;
    @(negedge clk); #1; divSel = 3'b110; setFreeze = 1'b0;
    @(negedge clk); #1; divSel = 3'b010;
    k = 0; firstDone = 0; busyCnt = 0;
    while (q.size() != 0 && k < 2000) begin
      @(negedge clk); #1;
      k++;
      if (firstDone == 0 && updBusy) busyCnt++;
      if (firstDone == 0 && updDone) firstDone = k;
    end
    setFreeze = 1'b1;
    check(firstDone == TICKS / 2 + 1, "R3 first rollover after half second", 64'(firstDone), 64'(TICKS / 2 + 1));
    check(busyCnt == BUSYT, "R4 busy window length", 64'(busyCnt), 64'(BUSYT));
    check(q.size() == 0, "R4 all rollovers seen", 64'(q.size()), 64'd0);
  endtask

  task automatic quietWindow(input int n, input string tag);
    int ev;
    logic [63:0] t0;
    ev = 0;
    t0 = nowTime();
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (updBusy || updDone || alarmHit) ev++;
    end
    check(ev == 0, {tag, " no events"}, 64'(ev), 64'd0);
    check(nowTime() == t0, {tag, " time held"}, nowTime(), t0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    check(nowTime() == 64'h00_00_01_01_01_00_00_00, "R1 reset time", nowTime(), 64'h00_00_01_01_01_00_00_00);
    check({updBusy, updDone, alarmHit} == 3'b000, "R1 reset strobes", 64'({updBusy, updDone, alarmHit}), 64'd0);

    // packed decimal, 24-hour: load end of century
    alarmSec = 8'h00;
    loadField(3'd0, 8'h58); loadField(3'd1, 8'h59); loadField(3'd2, 8'h23); loadField(3'd3, 8'h07);
    loadField(3'd4, 8'h31); loadField(3'd5, 8'h12); loadField(3'd6, 8'h99); loadField(3'd7, 8'h20);
    check(nowTime() == 64'h20_99_12_31_07_23_59_58, "R10 R5 load readback", nowTime(), 64'h20_99_12_31_07_23_59_58);

    @(negedge clk); #1; setFreeze = 1'b0;
    quietWindow(80, "R2 prescaler reset");

    expectRoll(64'h20_99_12_31_07_23_59_59, 1'b0, "R8 no match at :59");
    expectRoll(64'h21_00_01_01_01_00_00_00, 1'b1, "R7 R8 full carry with alarm");
    runUntilDrained();

    // load attempt while counting must be ignored
    @(negedge clk); #1; setFreeze = 1'b0;
    loadField(3'd0, 8'h33);
    check(timeSec == 8'h00, "R10 load ignored while counting", 64'(timeSec), 64'h00);
    setFreeze = 1'b1;
    quietWindow(100, "R11 frozen");
    @(negedge clk); #1; divSel = 3'b011; setFreeze = 1'b0;
    quietWindow(100, "R1 timebase stopped");
    setFreeze = 1'b1; divSel = 3'b010;

    // binary, 12-hour
    @(negedge clk); #1; binMode = 1'b1; hour24 = 1'b0;
    #1;
    check(timeHour == 8'h0C, "R6 midnight reads 12 AM", 64'(timeHour), 64'h0C);
    check(timeCentury == 8'd21, "R5 binary century", 64'(timeCentury), 64'd21);
    loadField(3'd2, 8'h8C);
    check(timeHour == 8'h8C, "R6 noon reads 12 PM", 64'(timeHour), 64'h8C);
    hour24 = 1'b1; #1;
    check(timeHour == 8'd12, "R6 noon in 24-hour", 64'(timeHour), 64'd12);
    hour24 = 1'b0;
    loadField(3'd2, 8'h8B); loadField(3'd1, 8'd59); loadField(3'd0, 8'd58);
    hour24 = 1'b1; #1;
    check(timeHour == 8'd23, "R6 11 PM in 24-hour", 64'(timeHour), 64'd23);
    hour24 = 1'b0;
    alarmSec = 8'hC5; alarmMin = 8'd0; alarmHour = 8'h0C;
    expectRoll({8'd21, 8'd0, 8'd1, 8'd1, 8'd1, 8'h8B, 8'd59, 8'd59}, 1'b0, "R9 no match at 11 PM");
    expectRoll({8'd21, 8'd0, 8'd1, 8'd2, 8'd2, 8'h0C, 8'd0, 8'd0}, 1'b1, "R9 R8 12 AM alarm hour");
    runUntilDrained();

    // binary, 24-hour calendar edges
    @(negedge clk); #1; hour24 = 1'b1;
    alarmSec = 8'd60; alarmMin = 8'hC0; alarmHour = 8'hC0;
    setTime(23, 59, 59, 3, 28, 2, 4);
    expectRoll({8'd21, 8'd4, 8'd2, 8'd29, 8'd4, 8'd0, 8'd0, 8'd0}, 1'b0, "R7 leap February");
    runUntilDrained();
    setTime(23, 59, 59, 3, 28, 2, 5);
    expectRoll({8'd21, 8'd5, 8'd3, 8'd1, 8'd4, 8'd0, 8'd0, 8'd0}, 1'b0, "R7 common February");
    runUntilDrained();
    setTime(23, 59, 59, 7, 30, 4, 5);
    expectRoll({8'd21, 8'd5, 8'd5, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0}, 1'b0, "R7 30-day month and weekday wrap");
    runUntilDrained();
    setTime(23, 59, 59, 2, 30, 1, 5);
    expectRoll({8'd21, 8'd5, 8'd1, 8'd31, 8'd3, 8'd0, 8'd0, 8'd0}, 1'b0, "R7 31-day month");
    runUntilDrained();

    repeat (5) @(negedge clk);
    finish();
  end

  initial begin
    #1000000;
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish();
  end
endmodule